// File: doc/BRIEF.md
# External Memory Bus Cycle Controller

This block sits between an 8-bit processor core and an external parallel memory with a 16-bit data path. The core issues table read and table write requests. Each request carries an address, one latch byte, a latch select (low or high latch byte) and a read/write flag. The block turns each request into one timed bus cycle. During that cycle it drives the address, the data lanes, the write-high and write-low strobes, the upper-byte and lower-byte selects and a read strobe. It pulses a done handshake when the cycle is over.

A single 8-bit control register sets three things. The first is how many wait clocks are added to every bus cycle, with the code counted in reverse. The second is how a byte write is placed on the two data lanes and which strobes fire. The third is whether the external bus or the general I/O ports own the shared pins. A mode input tells the block whether the processor uses external memory at all. When it does not, the register refuses writes.

Top module: `xbus_ctrl`

## Requirements
- R1: The control register has a pin-release flag at bit 7, a wait code at bits 5:4 and a write mode at bits 1:0. Bits 6, 3 and 2 read as 0, and every field resets to 0. Writing 0xFF therefore reads back 0xB3.
- R2: A bus cycle holds its strobes for 1 + (3 - wait code) clocks. Code 3 gives 1 clock, 2 gives 2, 1 gives 3 and 0 gives 4. The same rule applies to reads and writes.
- R3: With the pin-release flag at 0, `pins_bus_o` is 1 at all times. With the flag at 1, `pins_bus_o` is 1 only while a bus cycle is running and 0 when idle.
- R4: In word mode (write mode 2 or 3), a write to the low latch byte only stores that byte and gives no bus cycle and no strobe. It still pulses done. A write to the high latch byte then runs one cycle with data {high byte, stored low byte} and only `wrh_o` active.
- R5: In byte-select mode (write mode 1), the byte is driven on both lanes. `wrh_o` is active together with `ub_o` when address bit 0 is 1, or with `lb_o` when address bit 0 is 0.
- R6: In byte-write mode (write mode 0), the byte is driven on both lanes. Only `wrh_o` is active when address bit 0 is 1, and only `wrl_o` when address bit 0 is 0.
- R7: While `ext_mem_i` is 0, register writes have no effect on the register.
- R8: `done_o` is high for exactly one clock, in the clock after the last strobe clock. `req_ready_o` is 0 for the whole bus cycle, so no new request is taken until the cycle ends.
- R9: A read cycle asserts only `rd_o`. `rdata_o` then returns `bus_din_i[15:8]` when address bit 0 is 1 and `bus_din_i[7:0]` when it is 0. The value is valid while `done_o` is high.
- R10: All strobes and `bus_doe_o` are 0 outside a bus cycle. `bus_doe_o` is 1 only during write cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ext_mem_i | input | 1 | Processor uses external memory; when 0 the register refuses writes |
| reg_we_i | input | 1 | Control register write enable |
| reg_wdata_i | input | 8 | Control register write data |
| reg_rdata_o | output | 8 | Control register read data |
| req_valid_i | input | 1 | Core request valid |
| req_ready_o | output | 1 | Block idle and able to take a request |
| req_write_i | input | 1 | 1 = table write, 0 = table read |
| req_hi_i | input | 1 | Latch byte select: 1 = high latch byte |
| req_addr_i | input | AW | Request address; bit 0 picks the lane |
| req_data_i | input | 8 | Latch byte for writes |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 8 | Byte returned by a read |
| bus_addr_o | output | AW | External address |
| bus_dout_o | output | 16 | External write data |
| bus_doe_o | output | 1 | Drive enable for the write data |
| bus_din_i | input | 16 | External read data |
| wrh_o | output | 1 | Write-high strobe |
| wrl_o | output | 1 | Write-low strobe |
| ub_o | output | 1 | Upper-byte select |
| lb_o | output | 1 | Lower-byte select |
| rd_o | output | 1 | Read strobe |
| pins_bus_o | output | 1 | 1 = bus owns the shared pins, 0 = I/O ports own them |

## Verification
The bench runs every wait code and checks the strobe length. A reversed decode would make code 3 the longest cycle instead of the shortest. It tests both lanes in byte-select and byte-write modes, where a wrong lane pick fires `ub_o` or `wrl_o` on the wrong address bit. The word-mode pair of writes shows up a design that launches a cycle on the low byte, or that drops the stored byte from the word. Register tests cover the reserved bits and writes made while external memory is off. The ownership tests show a design that gives the pins back to the ports in the middle of a cycle, or that never releases them.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef struct packed {
    logic       rel;    // pins released to ports when idle
    logic [1:0] wcode;  // wait code, reverse encoded
    logic [1:0] wmode;  // 00 byte-write, 01 byte-select, 1x word
  } cfg_t;

  typedef struct packed {
    logic wrh;
    logic wrl;
    logic ub;
    logic lb;
    logic rd;
  } strb_t;

  function automatic logic [1:0] wait_of(input logic [1:0] code);
    return ~code;
  endfunction
endpackage

// File: rtl/xbus_cfg_reg.sv
module xbus_cfg_reg
  import xbus_pkg::*;
#(
  parameter int RW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [RW-1:0] wdata_i,
  output cfg_t          cfg_o,
  output logic [RW-1:0] rdata_o
);
  cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else if (we_i && en_i) begin
      cfg_q.rel   <= wdata_i[7];
      cfg_q.wcode <= wdata_i[5:4];
      cfg_q.wmode <= wdata_i[1:0];
    end
  end

  always_comb begin
    rdata_o      = '0;
    rdata_o[7]   = cfg_q.rel;
    rdata_o[5:4] = cfg_q.wcode;
    rdata_o[1:0] = cfg_q.wmode;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/xbus_lane_map.sv
module xbus_lane_map
  import xbus_pkg::*;
#(
  parameter int BW = 8,
  localparam int DW = 2 * BW
) (
  input  logic [1:0]    wmode_i,
  input  logic          write_i,
  input  logic          hi_i,
  input  logic          a0_i,
  input  logic [BW-1:0] data_i,
  input  logic [BW-1:0] lo_latch_i,
  output logic          launch_o,
  output strb_t         strb_o,
  output logic [DW-1:0] dout_o
);
  always_comb begin
    strb_o   = '0;
    dout_o   = {data_i, data_i};
    launch_o = 1'b1;
    if (!write_i) begin
      strb_o.rd = 1'b1;
    end else if (wmode_i[1]) begin
      // word: low byte only latched, high byte launches
      launch_o   = hi_i;
      dout_o     = {data_i, lo_latch_i};
      strb_o.wrh = hi_i;
    end else if (wmode_i[0]) begin
      strb_o.wrh = 1'b1;
      strb_o.ub  = a0_i;
      strb_o.lb  = !a0_i;
    end else begin
      strb_o.wrh = a0_i;
      strb_o.wrl = !a0_i;
    end
  end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int AW = 20,
  parameter int BW = 8,
  parameter int CW = 2,
  localparam int DW = 2 * BW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          launch_i,
  input  logic [CW-1:0] wait_i,
  input  strb_t         strb_i,
  input  logic [DW-1:0] dout_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] din_i,
  output logic          busy_o,
  output strb_t         strb_o,
  output logic [DW-1:0] dout_o,
  output logic [AW-1:0] addr_o,
  output logic          done_o,
  output logic [BW-1:0] rdata_o
);
  logic          busy_q, done_q;
  logic [CW-1:0] cnt_q;
  strb_t         strb_q;
  logic [DW-1:0] dout_q;
  logic [AW-1:0] addr_q;
  logic [BW-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      cnt_q   <= '0;
      strb_q  <= '0;
      dout_q  <= '0;
      addr_q  <= '0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          if (launch_i) begin
            busy_q <= 1'b1;
            cnt_q  <= wait_i;
            strb_q <= strb_i;
            dout_q <= dout_i;
            addr_q <= addr_i;
          end else begin
            done_q <= 1'b1;
          end
        end
      end else if (cnt_q == '0) begin
        busy_q <= 1'b0;
        strb_q <= '0;
        done_q <= 1'b1;
        if (strb_q.rd) rdata_q <= addr_q[0] ? din_i[DW-1:BW] : din_i[BW-1:0];
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign busy_o  = busy_q;
  assign strb_o  = strb_q;
  assign dout_o  = dout_q;
  assign addr_o  = addr_q;
  assign done_o  = done_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int AW = 20,
  parameter int BW = 8,
  localparam int DW = 2 * BW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ext_mem_i,
  input  logic          reg_we_i,
  input  logic [BW-1:0] reg_wdata_i,
  output logic [BW-1:0] reg_rdata_o,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_write_i,
  input  logic          req_hi_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [BW-1:0] req_data_i,
  output logic          done_o,
  output logic [BW-1:0] rdata_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_dout_o,
  output logic          bus_doe_o,
  input  logic [DW-1:0] bus_din_i,
  output logic          wrh_o,
  output logic          wrl_o,
  output logic          ub_o,
  output logic          lb_o,
  output logic          rd_o,
  output logic          pins_bus_o
);
  cfg_t          cfg;
  strb_t         strb_n, strb;
  logic [DW-1:0] dout_n;
  logic          launch, start, busy;
  logic [BW-1:0] lo_q;

  xbus_cfg_reg #(.RW(BW)) u_cfg (
    .clk_i, .rst_ni,
    .en_i    (ext_mem_i),
    .we_i    (reg_we_i),
    .wdata_i (reg_wdata_i),
    .cfg_o   (cfg),
    .rdata_o (reg_rdata_o)
  );

  xbus_lane_map #(.BW(BW)) u_map (
    .wmode_i    (cfg.wmode),
    .write_i    (req_write_i),
    .hi_i       (req_hi_i),
    .a0_i       (req_addr_i[0]),
    .data_i     (req_data_i),
    .lo_latch_i (lo_q),
    .launch_o   (launch),
    .strb_o     (strb_n),
    .dout_o     (dout_n)
  );

  assign start = req_valid_i && !busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lo_q <= '0;
    else if (start && req_write_i && !req_hi_i && cfg.wmode[1]) lo_q <= req_data_i;
  end

  xbus_seq #(.AW(AW), .BW(BW), .CW(2)) u_seq (
    .clk_i, .rst_ni,
    .start_i  (start),
    .launch_i (launch),
    .wait_i   (wait_of(cfg.wcode)),
    .strb_i   (strb_n),
    .dout_i   (dout_n),
    .addr_i   (req_addr_i),
    .din_i    (bus_din_i),
    .busy_o   (busy),
    .strb_o   (strb),
    .dout_o   (bus_dout_o),
    .addr_o   (bus_addr_o),
    .done_o   (done_o),
    .rdata_o  (rdata_o)
  );

  assign req_ready_o = !busy;
  assign wrh_o       = strb.wrh;
  assign wrl_o       = strb.wrl;
  assign ub_o        = strb.ub;
  assign lb_o        = strb.lb;
  assign rd_o        = strb.rd;
  assign bus_doe_o   = busy && (strb.wrh || strb.wrl);
  assign pins_bus_o  = !cfg.rel || busy;
endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk #(
  parameter int AW = 20,
  parameter int BW = 8,
  localparam int DW = 2 * BW
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ext_mem_i,
  input logic          reg_we_i,
  input logic [BW-1:0] reg_wdata_i,
  input logic [BW-1:0] reg_rdata_o,
  input logic          req_valid_i,
  input logic          req_ready_o,
  input logic          req_write_i,
  input logic          req_hi_i,
  input logic [AW-1:0] req_addr_i,
  input logic [BW-1:0] req_data_i,
  input logic          done_o,
  input logic [BW-1:0] rdata_o,
  input logic [AW-1:0] bus_addr_o,
  input logic [DW-1:0] bus_dout_o,
  input logic          bus_doe_o,
  input logic [DW-1:0] bus_din_i,
  input logic          wrh_o,
  input logic          wrl_o,
  input logic          ub_o,
  input logic          lb_o,
  input logic          rd_o,
  input logic          pins_bus_o
);
  p_reserved_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[6] == 1'b0 && reg_rdata_o[3:2] == 2'b00);

  p_bus_owns_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrh_o || wrl_o || rd_o) |-> pins_bus_o);

  p_one_lane_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ub_o, lb_o}));

  p_one_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wrh_o && wrl_o));

  p_reg_locked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_mem_i |=> $stable(reg_rdata_o));

  p_hold_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrh_o || wrl_o || rd_o) |-> !req_ready_o);

  p_read_alone_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |-> !(wrh_o || wrl_o || ub_o || lb_o));

  p_doe_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_doe_o |-> (wrh_o || wrl_o));
endmodule

bind xbus_ctrl xbus_ctrl_chk #(.AW(AW), .BW(BW)) u_chk (.*);

// File: tb/sim_xbus_ctrl.sv
`timescale 1ns/1ps
module sim_xbus_ctrl;
  localparam int AW = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        ext_mem = 1'b1, reg_we = 1'b0;
  logic [7:0]  reg_wdata = '0, reg_rdata;
  logic        req_valid = 1'b0, req_ready, req_write = 1'b0, req_hi = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]  req_data = '0, rdata;
  logic        done;
  logic [AW-1:0] bus_addr;
  logic [15:0] bus_dout, bus_din = '0;
  logic        bus_doe, wrh, wrl, ub, lb, rd, pins_bus;

  xbus_ctrl #(.AW(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ext_mem_i(ext_mem),
    .reg_we_i(reg_we), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_hi_i(req_hi), .req_addr_i(req_addr), .req_data_i(req_data),
    .done_o(done), .rdata_o(rdata), .bus_addr_o(bus_addr), .bus_dout_o(bus_dout),
    .bus_doe_o(bus_doe), .bus_din_i(bus_din), .wrh_o(wrh), .wrl_o(wrl),
    .ub_o(ub), .lb_o(lb), .rd_o(rd), .pins_bus_o(pins_bus)
  );

  typedef struct packed {
    logic [7:0]  cfg;
    logic        wr;
    logic        hi;
    logic        a0;
    logic [7:0]  dat;
    logic [3:0]  es;   // {wrh, wrl, ub, lb}
    logic [15:0] ed;
    logic [2:0]  el;   // strobe clocks, 0 = no bus cycle
  } vec_t;

  localparam int NV = 9;
  localparam vec_t TBL [NV] = '{
    '{8'h00, 1'b1, 1'b0, 1'b1, 8'hA5, 4'b1000, 16'hA5A5, 3'd4},  // R6 R2
    '{8'h30, 1'b1, 1'b0, 1'b0, 8'h3C, 4'b0100, 16'h3C3C, 3'd1},  // R6 R2
    '{8'h21, 1'b1, 1'b0, 1'b1, 8'h5A, 4'b1010, 16'h5A5A, 3'd2},  // R5 R2
    '{8'h11, 1'b1, 1'b0, 1'b0, 8'hC3, 4'b1001, 16'hC3C3, 3'd3},  // R5 R2
    '{8'h32, 1'b1, 1'b0, 1'b0, 8'h11, 4'b0000, 16'h0000, 3'd0},  // R4 low
    '{8'h32, 1'b1, 1'b1, 1'b0, 8'h22, 4'b1000, 16'h2211, 3'd1},  // R4 high
    '{8'h23, 1'b1, 1'b0, 1'b1, 8'h77, 4'b0000, 16'h0000, 3'd0},  // R4 low
    '{8'h23, 1'b1, 1'b1, 1'b1, 8'h88, 4'b1000, 16'h8877, 3'd2},  // R4 high
    '{8'h81, 1'b1, 1'b0, 1'b1, 8'h0F, 4'b1010, 16'h0F0F, 3'd4}   // R5 R3
  };

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] v);
    @(negedge clk); reg_we = 1'b1; reg_wdata = v;
    @(negedge clk); reg_we = 1'b0;
  endtask

  // issue one request; report strobe length and first-clock bus state
  task automatic do_req(input logic w, input logic h, input logic [AW-1:0] a,
                        input logic [7:0] d, output int len, output logic [3:0] s,
                        output logic [15:0] dq, output logic r, output logic rdy,
                        output logic own, output logic doe);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_hi = h; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    s = {wrh, wrl, ub, lb}; dq = bus_dout; r = rd; rdy = req_ready;
    own = pins_bus; doe = bus_doe;
    len = 0;
    while (!done && len < 20) begin
      len++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int len;
    logic [3:0] s;
    logic [15:0] dq;
    logic r, rdy, own, doe;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R1 reset reg", reg_rdata, 8'h00);
    chk("R10 reset strobes", {wrh, wrl, ub, lb, rd, bus_doe}, 6'b0);
    chk("R8 reset ready", req_ready, 1'b1);
    chk("R3 reset own", pins_bus, 1'b1);

    for (int i = 0; i < NV; i++) begin
      wr_reg(TBL[i].cfg);
      do_req(TBL[i].wr, TBL[i].hi, {{(AW-1){1'b0}}, TBL[i].a0} | 20'h01230,
             TBL[i].dat, len, s, dq, r, rdy, own, doe);
      chk($sformatf("R2 len v%0d", i), len, TBL[i].el);
      if (TBL[i].el == 0) begin
        chk($sformatf("R4 no cycle v%0d", i), {s, r, doe}, 6'b0);
      end else begin
        chk($sformatf("R5 R6 strobes v%0d", i), s, TBL[i].es);
        chk($sformatf("R4 data v%0d", i), dq, TBL[i].ed);
        chk($sformatf("R8 busy v%0d", i), rdy, 1'b0);
        chk($sformatf("R10 doe v%0d", i), doe, 1'b1);
        chk($sformatf("R3 own v%0d", i), own, 1'b1);
      end
      chk($sformatf("R8 done pulse v%0d", i), done, 1'b1);
      @(negedge clk);
      chk($sformatf("R8 done once v%0d", i), done, 1'b0);
      chk($sformatf("R10 idle v%0d", i), {wrh, wrl, ub, lb, rd, bus_doe}, 6'b0);
    end

    // R1 reserved bits
    wr_reg(8'hFF);
    chk("R1 readback", reg_rdata, 8'hB3);
    // R3 released pins when idle
    chk("R3 idle released", pins_bus, 1'b0);
    wr_reg(8'h00);
    chk("R3 idle bus", pins_bus, 1'b1);

    // R7 locked register
    wr_reg(8'h32);
    ext_mem = 1'b0;
    wr_reg(8'h81);
    chk("R7 ignored write", reg_rdata, 8'h32);
    ext_mem = 1'b1;

    // R9 reads, both lanes, with wait code 2 -> 2 clocks
    wr_reg(8'h20);
    bus_din = 16'hBEEF;
    do_req(1'b0, 1'b0, 20'h00041, 8'h00, len, s, dq, r, rdy, own, doe);
    chk("R9 read strobe", {s, r}, 5'b00001);
    chk("R10 read no doe", doe, 1'b0);
    chk("R2 read len", len, 2);
    chk("R9 read upper", rdata, 8'hBE);
    do_req(1'b0, 1'b0, 20'h00040, 8'h00, len, s, dq, r, rdy, own, doe);
    chk("R9 read lower", rdata, 8'hEF);
    chk("R8 read busy", rdy, 1'b0);

    // R2 read with code 0 -> 4 clocks
    wr_reg(8'h00);
    do_req(1'b0, 1'b0, 20'h00002, 8'h00, len, s, dq, r, rdy, own, doe);
    chk("R2 read len4", len, 4);

    // R8 request held off during a long cycle
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_hi = 1'b0; req_addr = 20'h1; req_data = 8'h44;
    @(negedge clk);
    // still asserting valid with new data; must not be accepted mid-cycle
    req_data = 8'h99; req_addr = 20'h0;
    @(negedge clk);
    chk("R8 held data", bus_dout, 16'h4444);
    chk("R8 held strobe", {wrh, wrl}, 2'b10);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule